// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming frame should be kept by looking only at its 48-bit destination address. Two mechanisms can each accept the address. The first is a bank of exact-match slots, and each slot holds one full address. The second is a 4096-bit hash table that covers multicast addresses. A 2-bit filter-type input chooses which twelve upper address bits index the table.

Configuration uses a simple word-wide write port. The top bit of the write address selects the hash table, where the remaining bits give the table word. When that top bit is clear, the low bits select a slot and whether the low or the high word of that slot is written. The slot index sits in bits 4:1 and the word select in bit 0.

Lookups arrive one per cycle with a strobe. One cycle later the block returns accept, exact-hit and hash-hit flags together with a result strobe.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, every slot is invalid and every hash-table bit is zero, so no lookup hits. All result outputs are low until the first lookup has been answered.
- R2: Slot words are little-endian. The address is numbered with byte 0 in bits 7:0. The low word (write address `{slot,0}`) takes address bits 31:0, and bits 15:0 of the high word (write address `{slot,1}`) take address bits 47:32.
- R3: A slot takes part in matching only while bit 31 of its high word is 1. Writing 0 to the high word removes the slot from matching at once.
- R4: An exact hit requires all 48 bits to equal a valid slot's address. An address that differs in any single bit does not hit.
- R5: The hash is selected by the filter type. Type 0 uses address bits 47:36, type 1 uses 46:35, type 2 uses 45:34, and type 3 uses 43:32.
- R6: Table words are written at write address `128 + h[11:5]`. Hash bits 11:5 pick the 32-bit table word and bits 4:0 pick the bit inside it.
- R7: A hash hit is only possible for a multicast address, meaning address bit 0 is 1. A unicast address never produces a hash hit.
- R8: Results appear exactly one cycle after the lookup strobe, and `res_valid` follows the strobe cycle by cycle. When no lookup was made, all flags are 0.
- R9: A write and a lookup in the same cycle: the lookup sees the table and slot contents from before the write.
- R10: Writes with the top address bit clear and address bits 6:5 non-zero are ignored.
- R11: `accept` is 1 exactly when the exact hit or the hash hit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Word address: bit 7 selects table, else slot word |
| wr_data | input | 32 | Configuration write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| lk_ftype | input | 2 | Hash window select |
| res_valid | output | 1 | Result strobe, one cycle after lk_valid |
| accept | output | 1 | Frame accepted |
| exact_hit | output | 1 | Some valid slot matched |
| hash_hit | output | 1 | Multicast hash bit was set |

## Verification
A configuration write and a lookup can land in the same cycle. The write may target the very table bit, or the very slot, that the lookup reads. The bench provokes this by issuing the write together with a lookup of the affected address. It expects the lookup to see the old contents, and it expects the next lookup of the same address to see the new contents. A second collision sets the valid bit of a slot while that slot's own address is looked up in the same cycle.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  localparam int MAC_W  = 48;
  localparam int WORD_W = 32;
  localparam int HASH_W = 12;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int TBL_AW = HASH_W - BIT_W;
  localparam int TBL_WORDS = 1 << TBL_AW;
  localparam int VLD_BIT = 31;

  typedef enum logic [1:0] {
    WIN_47_36 = 2'd0,
    WIN_46_35 = 2'd1,
    WIN_45_34 = 2'd2,
    WIN_43_32 = 2'd3
  } win_sel_e;

  // Picks the twelve hash bits out of the address for a given window.
  function automatic logic [HASH_W-1:0] hash_window(input logic [MAC_W-1:0] a,
                                                   input logic [1:0] sel);
    case (win_sel_e'(sel))
      WIN_47_36: hash_window = a[47 -: HASH_W];
      WIN_46_35: hash_window = a[46 -: HASH_W];
      WIN_45_34: hash_window = a[45 -: HASH_W];
      default:   hash_window = a[43 -: HASH_W];
    endcase
  endfunction

  function automatic logic [TBL_AW-1:0] hash_word(input logic [HASH_W-1:0] h);
    hash_word = h[HASH_W-1:BIT_W];
  endfunction

  function automatic logic [BIT_W-1:0] hash_bit(input logic [HASH_W-1:0] h);
    hash_bit = h[BIT_W-1:0];
  endfunction
endpackage

// File: rtl/rdf_slot_bank.sv
module rdf_slot_bank
  import rx_da_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int SLOT_AW = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_AW-1:0]   wr_word,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [MAC_W-1:0]     lk_addr,
  output logic [NUM_SLOTS-1:0] hit_vec,
  output logic [NUM_SLOTS-1:0] vld_vec
);
  localparam int HI_W = MAC_W - WORD_W;

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[VLD_BIT-1:HI_W];

  logic [IDX_W-1:0] wr_idx;
  logic             wr_is_hi;
  assign wr_idx   = wr_word[SLOT_AW-1:1];
  assign wr_is_hi = wr_word[0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              vld_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (sel) begin
        if (wr_is_hi) begin
          hi_q  <= wr_data[HI_W-1:0];
          vld_q <= wr_data[VLD_BIT];
        end else begin
          lo_q <= wr_data;
        end
      end
    end

    assign hit_vec[s] = vld_q && ({hi_q, lo_q} == lk_addr);
    assign vld_vec[s] = vld_q;
  end
endmodule

// File: rtl/rdf_hash_table.sv
module rdf_hash_table
  import rx_da_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TBL_AW-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [HASH_W-1:0] rd_hash,
  output logic              rd_bit
);
  logic [WORD_W-1:0] tbl_q [TBL_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < TBL_WORDS; w++) tbl_q[w] <= '0;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_data;
    end
  end

  logic [WORD_W-1:0] rd_word;
  assign rd_word = tbl_q[hash_word(rd_hash)];
  assign rd_bit  = rd_word[hash_bit(rd_hash)];
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int SLOT_AW = IDX_W + 1,
  localparam int WR_AW = ((SLOT_AW > TBL_AW) ? SLOT_AW : TBL_AW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WR_AW-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lk_valid,
  input  logic [MAC_W-1:0]  lk_addr,
  input  logic [1:0]        lk_ftype,
  output logic              res_valid,
  output logic              accept,
  output logic              exact_hit,
  output logic              hash_hit
);
  // Write decode
  logic [WR_AW-1:0] wr_low;
  logic             tbl_wr;
  logic             slot_wr;
  assign wr_low  = wr_addr & {1'b0, {(WR_AW-1){1'b1}}};
  assign tbl_wr  = wr_en && wr_addr[WR_AW-1];
  assign slot_wr = wr_en && !wr_addr[WR_AW-1] && ((wr_low >> SLOT_AW) == '0);

  // Exact-match slots
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] vld_vec;
  rdf_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (slot_wr),
    .wr_word (wr_addr[SLOT_AW-1:0]),
    .wr_data (wr_data),
    .lk_addr (lk_addr),
    .hit_vec (hit_vec),
    .vld_vec (vld_vec)
  );

  // Hash table
  logic [HASH_W-1:0] lk_hash;
  logic              tbl_bit;
  assign lk_hash = hash_window(lk_addr, lk_ftype);
  rdf_hash_table u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr),
    .wr_idx  (wr_addr[TBL_AW-1:0]),
    .wr_data (wr_data),
    .rd_hash (lk_hash),
    .rd_bit  (tbl_bit)
  );

  // Named events for the checker
  logic lk_is_mcast;
  logic exact_now;
  logic hash_now;
  logic slot_any_valid;
  assign lk_is_mcast    = lk_addr[0];
  assign exact_now      = |hit_vec;
  assign hash_now       = lk_is_mcast && tbl_bit;
  assign slot_any_valid = |vld_vec;

  // Result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      exact_hit <= 1'b0;
      hash_hit  <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      accept    <= lk_valid && (exact_now || hash_now);
      exact_hit <= lk_valid && exact_now;
      hash_hit  <= lk_valid && hash_now;
    end
  end
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_mcast,
  input logic slot_any_valid,
  input logic res_valid,
  input logic accept,
  input logic exact_hit,
  input logic hash_hit
);
  assert_result_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !accept && !exact_hit && !hash_hit));

  assert_hash_only_mcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hash_hit |-> $past(lk_mcast));

  assert_exact_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exact_hit |-> $past(slot_any_valid));

  assert_accept_from_hits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (exact_hit || hash_hit));

  assert_hits_give_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exact_hit || hash_hit) |-> accept);
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lk_valid       (lk_valid),
  .lk_mcast       (lk_is_mcast),
  .slot_any_valid (slot_any_valid),
  .res_valid      (res_valid),
  .accept         (accept),
  .exact_hit      (exact_hit),
  .hash_hit       (hash_hit)
);

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic [1:0]  lk_ftype = '0;
  logic        res_valid, accept, exact_hit, hash_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_da_filter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ftype(lk_ftype),
    .res_valid(res_valid), .accept(accept), .exact_hit(exact_hit), .hash_hit(hash_hit)
  );

  // Reference state
  logic [31:0] m_lo  [16];
  logic [31:0] m_hi  [16];
  logic [31:0] m_tbl [128];

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [11:0] ref_hash(logic [47:0] a, logic [1:0] ft);
    logic [15:0] b4, b5, h;
    b4 = {8'h00, a[39:32]};
    b5 = {8'h00, a[47:40]};
    case (ft)
      2'd0: h = (b4 >> 4) | (b5 << 4);
      2'd1: h = (b4 >> 3) | (b5 << 5);
      2'd2: h = (b4 >> 2) | (b5 << 6);
      default: h = b4 | (b5 << 8);
    endcase
    return h[11:0];
  endfunction

  function automatic logic [2:0] ref_eval(logic [47:0] a, logic [1:0] ft);
    logic ex, hh;
    logic [11:0] h;
    logic [31:0] w;
    ex = 1'b0;
    for (int s = 0; s < 16; s++)
      if (m_hi[s][31] && ({m_hi[s][15:0], m_lo[s]} == a)) ex = 1'b1;
    h = ref_hash(a, ft);
    w = m_tbl[h / 32];
    hh = a[0] && w[h % 32];
    return {ex | hh, ex, hh};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus: optional write, optional lookup.
  // The lookup is judged against the state before the write (R9).
  task automatic step(bit we, logic [7:0] wa, logic [31:0] wd,
                      bit le, logic [47:0] la, logic [1:0] ft, string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    lk_valid = le; lk_addr = la; lk_ftype = ft;
    if (le) begin
      it.exp = ref_eval(la, ft);
      it.tag = tag;
      sb_q.push_back(it);
    end
    if (we) begin
      if (wa[7]) m_tbl[wa[6:0]] = wd;
      else if (wa[6:5] == 2'b00) begin
        if (wa[0]) m_hi[wa[4:1]] = wd; else m_lo[wa[4:1]] = wd;
      end
    end
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0, "");
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(1, a, d, 0, '0, '0, "");
  endtask

  task automatic look(logic [47:0] a, logic [1:0] ft, string tag);
    step(0, '0, '0, 1, a, ft, tag);
  endtask

  task automatic prog_slot(int s, logic [47:0] a, bit v);
    wr(8'(s * 2), a[31:0]);
    wr(8'(s * 2 + 1), {v, 15'h0, a[47:32]});
  endtask

  function automatic logic [7:0] tbl_addr(logic [47:0] a, logic [1:0] ft);
    logic [11:0] h;
    h = ref_hash(a, ft);
    return {1'b1, h[11:5]};
  endfunction

  function automatic logic [31:0] tbl_set(logic [47:0] a, logic [1:0] ft, int flip);
    logic [11:0] h;
    h = ref_hash(a, ft);
    return m_tbl[h[11:5]] | (32'h1 << (h[4:0] ^ 5'(flip)));
  endfunction

  // Monitor: compares every cycle just after the clock edge
  initial begin
    forever begin
      bit pend;
      item_t it;
      @(posedge clk);
      pend = lk_valid && rst_n;
      #1;
      if (rst_n) begin
        check("R8 res_valid follows strobe", {31'h0, res_valid}, {31'h0, pend});
        if (pend && sb_q.size() > 0) begin
          it = sb_q.pop_front();
          check(it.tag, {29'h0, accept, exact_hit, hash_hit}, {29'h0, it.exp});
        end else if (!pend) begin
          check("R8 idle flags low", {29'h0, accept, exact_hit, hash_hit}, 32'h0);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [47:0] ua, ma, mb, rev;
    for (int s = 0; s < 16; s++) begin m_lo[s] = '0; m_hi[s] = '0; end
    for (int w = 0; w < 128; w++) m_tbl[w] = '0;

    repeat (3) @(negedge clk);
    check("R1 outputs after reset", {28'h0, res_valid, accept, exact_hit, hash_hit}, 32'h0);
    rst_n = 1'b1;
    idle();

    // R1: everything empty
    look(48'hFFFF_FFFF_FFFF, 2'd0, "R1 empty table type0");
    look(48'hFFFF_FFFF_FFFF, 2'd3, "R1 empty table type3");
    look(48'h0000_0000_0000, 2'd1, "R1 zero address no slot hit");
    idle();

    // R2 / R4: little-endian slot load and full compare
    ua = 48'h6655_4433_2210;
    prog_slot(3, ua, 1);
    look(ua, 2'd0, "R2 exact hit little-endian slot");
    rev = {ua[7:0], ua[15:8], ua[23:16], ua[31:24], ua[39:32], ua[47:40]};
    look(rev, 2'd0, "R2 byte-reversed address misses");
    look(ua ^ 48'h8000_0000_0000, 2'd0, "R4 bit 47 differs");
    look(ua ^ 48'h0000_0001_0000, 2'd0, "R4 bit 16 differs");
    look(ua ^ 48'h0000_0000_0002, 2'd2, "R4 bit 1 differs");
    idle();

    // R3: valid bit gating
    ua = 48'h0A0B_0C0D_0E02;
    prog_slot(5, ua, 0);
    look(ua, 2'd0, "R3 slot without valid bit misses");
    wr(8'd11, {1'b1, 15'h0, ua[47:32]});
    look(ua, 2'd0, "R3 valid bit set hits");
    wr(8'd11, 32'h0);
    look(ua, 2'd0, "R3 high word cleared misses");
    idle();

    // R5 / R6: each window, exact bit and neighbour bit
    ma = 48'hA5C3_9F17_2B01;
    for (int ft = 0; ft < 4; ft++) begin
      for (int w = 0; w < 128; w++) wr({1'b1, 7'(w)}, 32'h0);
      wr(tbl_addr(ma, 2'(ft)), tbl_set(ma, 2'(ft), 1));
      look(ma, 2'(ft), "R6 neighbour bit only misses");
      wr(tbl_addr(ma, 2'(ft)), tbl_set(ma, 2'(ft), 0));
      look(ma, 2'(ft), "R5 selected window hits");
      look(ma, 2'(ft ^ 1), "R5 other window per model");
      look(ma, 2'(ft ^ 2), "R5 far window per model");
    end
    idle();

    // R7: unicast with table bit set
    look(ma & ~48'h1, 2'd3, "R7 unicast never hash hits");
    look(ma, 2'd3, "R7 multicast counterpart hits");
    idle();

    // R11: exact and hash on the same address
    mb = 48'h1234_5678_9A01;
    prog_slot(7, mb, 1);
    wr(tbl_addr(mb, 2'd0), tbl_set(mb, 2'd0, 0));
    look(mb, 2'd0, "R11 both hits accept");
    look(mb, 2'd1, "R11 exact only per model");

    // R9: write and lookup in the same cycle
    mb = 48'hF0E1_D2C3_B4A5;
    step(1, tbl_addr(mb, 2'd2), tbl_set(mb, 2'd2, 0), 1, mb, 2'd2, "R9 same-cycle table write sees old");
    look(mb, 2'd2, "R9 next lookup sees new table bit");
    ua = 48'h0102_0304_0506;
    wr(8'd18, ua[31:0]);
    step(1, 8'd19, {1'b1, 15'h0, ua[47:32]}, 1, ua, 2'd0, "R9 same-cycle slot valid sees old");
    look(ua, 2'd0, "R9 next lookup sees slot");
    idle();

    // R10: unmapped writes ignored
    ua = 48'h7788_99AA_BBCC;
    prog_slot(0, ua, 1);
    wr(8'h21, 32'h0);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h41, 32'h0);
    look(ua, 2'd0, "R10 unmapped writes leave slot 0");

    // R8: back-to-back lookups
    for (int i = 0; i < 6; i++) look(ua ^ 48'(i), 2'(i), "R8 back-to-back lookup");
    idle(); idle(); idle();

    if (sb_q.size() != 0) check("R8 results outstanding", 32'(sb_q.size()), 32'h0);
    finish_run();
  end
endmodule